// File: doc/BRIEF.md
# Flow match routing decision unit

This unit sits behind a flow-table lookup in a receive path. For each lookup result it decides which exit ring of the reorder stage the frame goes to. It also raises drop and override flags. When asked to, it requests a write-back that marks the matched entry's destination as unusable.

The entry carries several routing inputs:
- a valid bit;
- a 2-bit handler code, which picks the source of the destination;
- a stored 5-bit destination;
- a drop bit and an offload-engine (PPE) use bit;
- a sticky "destination invalid" flag.

Two fallback destinations arrive from the address/peer search and from the classifier rule. A miss destination, the PPE ring ID and mode bits come from configuration.

The decision is registered. It appears one cycle after the lookup strobe, together with a decoded ring class.

Top module: `flow_route_resolve`

## Requirements
- R1: When `lk_vld` is high and `ent_valid` is 0, the next cycle shows `rt_vld`=1, `rt_miss`=1, `rt_dst`=`cfg_miss_dst`, `rt_drop`=0, `rt_ppe`=0 and no write-back. No other entry field has any effect.
- R2: For a usable match with drop and PPE inactive, handler code 0 or 2 yields `rt_dst`=`ent_dst`.
- R3: For a usable match with drop and PPE inactive, handler code 1 yields `peer_dst` and handler code 3 yields `cls_dst`.
- R4: A usable match with `ent_drop`=1 yields `rt_dst`=5 and `rt_drop`=1, whatever the handler and PPE bits are.
- R5: A usable match with `ent_ppe`=1 and no drop yields `rt_dst`=`cfg_ppe_ring` and `rt_ppe`=1. The override is skipped, and the handler decides, when `multi_buf`=1 and `cfg_ppe_single_only`=1.
- R6: The ring class of `rt_dst` is decoded as follows:
  - codes 0–4 set `rt_sw`, with `rt_sw_ring` equal to the code;
  - codes 7–10 set `rt_sw`, with `rt_sw_ring` equal to code−2;
  - code 6 sets `rt_fw`;
  - code 5 sets `rt_rel`;
  - codes 11–31 set `rt_remap`.

  Exactly one class flag is high.
- R7: With `cfg_ffrag_skip`=1, a valid entry seen with `first_frag`=1 is routed as a miss (`rt_miss`=1, `rt_dst`=`cfg_miss_dst`). In the same cycle as `rt_vld`, it raises `wb_req` for one cycle, with `wb_idx` equal to the lookup's `ent_idx`.
- R8: A valid entry whose `ent_dst_bad` is 1 is routed as a miss, ignoring drop, PPE and handler.
- R9: `rt_vld` is high only in the cycle after an `lk_vld` cycle. Between strobes, `rt_dst` and the flags hold their last values.
- R10: After reset, `rt_vld`=0, `wb_req`=0, `rt_dst`=0 and `rt_miss`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vld | input | 1 | Lookup result strobe |
| ent_idx | input | IDX_W | Index of the looked-up entry |
| ent_valid | input | 1 | Entry valid bit |
| ent_handler | input | 2 | Handler code |
| ent_dst | input | 5 | Destination stored in entry |
| ent_drop | input | 1 | Entry drop bit |
| ent_ppe | input | 1 | Entry PPE-use bit |
| ent_dst_bad | input | 1 | Sticky invalid-destination flag |
| peer_dst | input | 5 | Address/peer search destination |
| cls_dst | input | 5 | Classifier rule destination |
| first_frag | input | 1 | Frame is a first fragment |
| multi_buf | input | 1 | Frame spans multiple buffers |
| cfg_miss_dst | input | 5 | Destination used on a miss |
| cfg_ppe_ring | input | 5 | Programmed PPE ring ID |
| cfg_ppe_single_only | input | 1 | Suppress PPE override for multi-buffer frames |
| cfg_ffrag_skip | input | 1 | First-fragment destination-ignore mode |
| rt_vld | output | 1 | Decision valid pulse |
| rt_dst | output | 5 | Resolved destination code |
| rt_miss | output | 1 | Routed as lookup failure |
| rt_drop | output | 1 | Drop override applied |
| rt_ppe | output | 1 | PPE override applied |
| rt_sw | output | 1 | Destination is a software ring |
| rt_sw_ring | output | 4 | Software ring number |
| rt_fw | output | 1 | Destination is firmware |
| rt_rel | output | 1 | Destination is release ring |
| rt_remap | output | 1 | Destination left to downstream remap |
| wb_req | output | 1 | Write-back request setting the invalid flag |
| wb_idx | output | IDX_W | Entry index for the write-back |

## Verification
The bench targets the precedence chain: invalid entries carrying drop or PPE bits, bad-flag entries with drop set, and drop together with PPE. A design with the order swapped would send such frames to release or PPE rings instead of the miss destination. It also drives multi-buffer frames under both settings of the PPE suppression bit, so a design that ignores the suppression bit would emit the PPE ring. Handler codes 0 and 2 both appear, so a design that decodes code 2 as a fallback would be caught. The ring decode is exercised at codes 4, 5, 6, 7, 10 and 11, where an off-by-one in the 7–10 shift or the remap threshold would show up.

// File: rtl/flow_route_resolve.sv
module flow_route_resolve #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_vld,
  input  logic [IDX_W-1:0] ent_idx,
  input  logic             ent_valid,
  input  logic [1:0]       ent_handler,
  input  logic [4:0]       ent_dst,
  input  logic             ent_drop,
  input  logic             ent_ppe,
  input  logic             ent_dst_bad,
  input  logic [4:0]       peer_dst,
  input  logic [4:0]       cls_dst,
  input  logic             first_frag,
  input  logic             multi_buf,
  input  logic [4:0]       cfg_miss_dst,
  input  logic [4:0]       cfg_ppe_ring,
  input  logic             cfg_ppe_single_only,
  input  logic             cfg_ffrag_skip,
  output logic             rt_vld,
  output logic [4:0]       rt_dst,
  output logic             rt_miss,
  output logic             rt_drop,
  output logic             rt_ppe,
  output logic             rt_sw,
  output logic [3:0]       rt_sw_ring,
  output logic             rt_fw,
  output logic             rt_rel,
  output logic             rt_remap,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx
);
  localparam logic [4:0] REL_CODE = 5'd5;
  localparam logic [4:0] FW_CODE  = 5'd6;
  localparam logic [4:0] SW_HI_LO = 5'd7;
  localparam logic [4:0] SW_HI_HI = 5'd10;

  logic       ffrag_hit, failed, ppe_take;
  logic [4:0] hsel_dst, nxt_dst;

  assign ffrag_hit = ent_valid && first_frag && cfg_ffrag_skip;
  assign failed    = !ent_valid || ent_dst_bad || ffrag_hit;
  assign ppe_take  = ent_ppe && !(multi_buf && cfg_ppe_single_only);

  always_comb begin
    case (ent_handler)
      2'd1:    hsel_dst = peer_dst;
      2'd3:    hsel_dst = cls_dst;
      default: hsel_dst = ent_dst;
    endcase
  end

  assign nxt_dst = failed   ? cfg_miss_dst :
                   ent_drop ? REL_CODE     :
                   ppe_take ? cfg_ppe_ring : hsel_dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rt_vld  <= 1'b0;
      rt_dst  <= '0;
      rt_miss <= 1'b1;
      rt_drop <= 1'b0;
      rt_ppe  <= 1'b0;
      wb_req  <= 1'b0;
      wb_idx  <= '0;
    end else begin
      rt_vld <= lk_vld;
      wb_req <= lk_vld && ffrag_hit;
      if (lk_vld) begin
        rt_dst  <= nxt_dst;
        rt_miss <= failed;
        rt_drop <= !failed && ent_drop;
        rt_ppe  <= !failed && !ent_drop && ppe_take;
        wb_idx  <= ent_idx;
      end
    end
  end

  logic sw_lo, sw_hi;
  assign sw_lo      = rt_dst < REL_CODE;
  assign sw_hi      = rt_dst >= SW_HI_LO && rt_dst <= SW_HI_HI;
  assign rt_sw      = sw_lo || sw_hi;
  assign rt_sw_ring = sw_lo ? rt_dst[3:0] : (sw_hi ? 4'(rt_dst - 5'd2) : 4'd0);
  assign rt_fw      = rt_dst == FW_CODE;
  assign rt_rel     = rt_dst == REL_CODE;
  assign rt_remap   = rt_dst > SW_HI_HI;

  a_r1_miss_route: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vld && !ent_valid |=> rt_vld && rt_miss && !rt_drop && !rt_ppe && !wb_req
                             && rt_dst == $past(cfg_miss_dst));

  a_r4_drop_release: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vld && ent_valid && !ent_dst_bad && !(first_frag && cfg_ffrag_skip) && ent_drop
    |=> rt_dst == 5'd5 && rt_drop && !rt_ppe);

  a_r8_bad_flag_miss: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vld && ent_dst_bad |=> rt_miss && !rt_drop && !rt_ppe);

  a_r7_wb_with_decision: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> rt_vld && rt_miss);

  a_r9_no_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_vld |=> !rt_vld && !wb_req && $stable(rt_dst));

  a_r6_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rt_sw, rt_fw, rt_rel, rt_remap}) == 1);
endmodule

// File: tb/flow_route_resolve_test.sv
module flow_route_resolve_test;
  localparam int CLK_NS = 10;
  localparam int IDX_W  = 12;

  logic clk = 0, rst_n = 0;
  logic lk_vld = 0;
  logic [IDX_W-1:0] ent_idx = 0;
  logic ent_valid = 0, ent_drop = 0, ent_ppe = 0, ent_dst_bad = 0;
  logic [1:0] ent_handler = 0;
  logic [4:0] ent_dst = 0, peer_dst = 0, cls_dst = 0, cfg_miss_dst = 0, cfg_ppe_ring = 0;
  logic first_frag = 0, multi_buf = 0, cfg_ppe_single_only = 0, cfg_ffrag_skip = 0;
  logic rt_vld, rt_miss, rt_drop, rt_ppe, rt_sw, rt_fw, rt_rel, rt_remap, wb_req;
  logic [4:0] rt_dst;
  logic [3:0] rt_sw_ring;
  logic [IDX_W-1:0] wb_idx;

  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  flow_route_resolve #(.IDX_W(IDX_W)) uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic is_fail();
    return !ent_valid || ent_dst_bad || (first_frag && cfg_ffrag_skip);
  endfunction

  function automatic logic ppe_used();
    return ent_ppe && !(multi_buf && cfg_ppe_single_only);
  endfunction

  function automatic logic [4:0] model_dst();
    if (is_fail()) return cfg_miss_dst;
    if (ent_drop) return 5'd5;
    if (ppe_used()) return cfg_ppe_ring;
    case (ent_handler)
      2'd1: return peer_dst;
      2'd3: return cls_dst;
      default: return ent_dst;
    endcase
  endfunction

  function automatic string tag();
    if (!ent_valid) return "R1";
    if (ent_dst_bad) return "R8";
    if (first_frag && cfg_ffrag_skip) return "R7";
    if (ent_drop) return "R4";
    if (ent_ppe) return "R5";
    if (ent_handler[0]) return "R3";
    return "R2";
  endfunction

  task automatic chk_class(logic [4:0] d);
    logic sw;
    int ring;
    sw = (d <= 4) || (d >= 7 && d <= 10);
    ring = (d <= 4) ? d : (sw ? d - 2 : 0);
    chk("R6 sw", rt_sw, sw);
    if (sw) chk("R6 sw_ring", rt_sw_ring, ring);
    chk("R6 fw", rt_fw, d == 6);
    chk("R6 rel", rt_rel, d == 5);
    chk("R6 remap", rt_remap, d >= 11);
  endtask

  task automatic run_one();
    logic [4:0] ed;
    logic em, edr, ep, ew;
    logic [IDX_W-1:0] ix;
    string t;
    ed = model_dst(); em = is_fail();
    edr = !em && ent_drop; ep = !em && !ent_drop && ppe_used();
    ew = ent_valid && first_frag && cfg_ffrag_skip;
    ix = ent_idx; t = tag();
    lk_vld = 1;
    @(negedge clk);
    lk_vld = 0;
    chk({t, " R9 vld"}, rt_vld, 1);
    chk({t, " dst"}, rt_dst, ed);
    chk({t, " miss"}, rt_miss, em);
    chk({t, " drop"}, rt_drop, edr);
    chk({t, " ppe"}, rt_ppe, ep);
    chk("R7 wb_req", wb_req, ew);
    if (ew) chk("R7 wb_idx", wb_idx, ix);
    chk_class(ed);
  endtask

  task automatic set_entry(logic v, logic [1:0] h, logic [4:0] d, logic dr, logic pp, logic bad);
    ent_valid = v; ent_handler = h; ent_dst = d; ent_drop = dr; ent_ppe = pp; ent_dst_bad = bad;
    ent_idx = IDX_W'($urandom);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 vld", rt_vld, 0);
    chk("R10 wb", wb_req, 0);
    chk("R10 dst", rt_dst, 0);
    chk("R10 miss", rt_miss, 1);
    rst_n = 1;
    @(negedge clk);
    cfg_miss_dst = 5'd9; cfg_ppe_ring = 5'd20; peer_dst = 5'd3; cls_dst = 5'd14;

    set_entry(0, 2'd0, 5'd2, 1, 1, 0); run_one();          // R1 invalid with drop/ppe set
    set_entry(1, 2'd0, 5'd4, 0, 0, 0); run_one();          // R2 code 0, dst 4
    set_entry(1, 2'd2, 5'd7, 0, 0, 0); run_one();          // R2 code 2
    set_entry(1, 2'd1, 5'd0, 0, 0, 0); run_one();          // R3 peer
    set_entry(1, 2'd3, 5'd0, 0, 0, 0); run_one();          // R3 classifier
    set_entry(1, 2'd1, 5'd0, 1, 1, 0); run_one();          // R4 drop over ppe
    set_entry(1, 2'd0, 5'd1, 0, 1, 0); run_one();          // R5 ppe
    multi_buf = 1; cfg_ppe_single_only = 1;
    set_entry(1, 2'd0, 5'd10, 0, 1, 0); run_one();         // R5 suppressed
    cfg_ppe_single_only = 0;
    set_entry(1, 2'd0, 5'd10, 0, 1, 0); run_one();         // R5 multi-buf, not suppressed
    multi_buf = 0;
    set_entry(1, 2'd0, 5'd6, 1, 0, 1); run_one();          // R8 bad flag beats drop
    cfg_ffrag_skip = 1; first_frag = 1;
    set_entry(1, 2'd0, 5'd11, 0, 0, 0); run_one();         // R7 write-back
    first_frag = 0;
    set_entry(1, 2'd0, 5'd11, 0, 0, 0); run_one();         // R6 code 11 remap
    cfg_ffrag_skip = 0;
    set_entry(1, 2'd0, 5'd5, 0, 0, 0); run_one();          // R6 code 5

    @(negedge clk);
    chk("R9 idle vld", rt_vld, 0);
    chk("R9 hold dst", rt_dst, 5);
    chk("R9 idle wb", wb_req, 0);

    for (int i = 0; i < 400; i++) begin
      set_entry($urandom_range(0, 7) != 0, 2'($urandom), 5'($urandom),
                $urandom_range(0, 4) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0);
      peer_dst = 5'($urandom); cls_dst = 5'($urandom);
      cfg_miss_dst = 5'($urandom); cfg_ppe_ring = 5'($urandom);
      first_frag = $urandom_range(0, 3) == 0; multi_buf = 1'($urandom);
      cfg_ppe_single_only = 1'($urandom); cfg_ffrag_skip = 1'($urandom);
      run_one();
      if ($urandom_range(0, 3) == 0) begin
        logic [4:0] held;
        held = rt_dst;
        @(negedge clk);
        chk("R9 idle vld", rt_vld, 0);
        chk("R9 hold dst", rt_dst, held);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule